// File: doc/BRIEF.md
# Cross-Domain Reset Request Bridge

This block turns a reset request raised in one clock domain into a clean reset for logic in another clock domain. A request seen on any source clock edge is first widened by a counter in the source domain. The widened request is then combined with a raw asynchronous external reset. The combined signal clears a chain of destination-domain flops at once. The chain then refills one flop per destination edge, so the reset output goes active without waiting for a clock but releases only on a destination clock edge.

The chain flops clear to the active-reset level, so the output is held active from time zero while the external reset is applied. No clock edge is needed for this, and the output cannot briefly pulse inactive before the first clock arrives. A clock-stable qualifier freezes the release progress while the destination clock is not trusted. The output is a single flop, so every register it feeds leaves reset on the same destination edge. No data stream passes through the block: all pins are plain control signals with no handshake.

Top module: `xdom_reset_bridge`

## Requirements
- R1: The output `dst_rst_n` is active low. It is 0 whenever `ext_rst_n` is 0, and it goes to 0 within the same cycle that `ext_rst_n` falls, with no destination clock edge needed.
- R2: A 1 on `src_req` sampled at a rising `src_clk` edge drives `dst_rst_n` to 0 right after that edge, before the next source edge, with no destination clock edge needed.
- R3: The widened request stays active for `STRETCH_CYCLES` source cycles after the last source edge at which `src_req` was sampled 1. A new request seen during that window restarts the full count.
- R4: `dst_rst_n` changes from 0 to 1 only at a rising `dst_clk` edge. It does so at the `SYNC_STAGES`-th rising edge that satisfies all of the following: `dst_clk_ok` was 1 at that edge, `ext_rst_n` was 1 throughout, and the widened request was inactive throughout.
- R5: Each period of `dst_rst_n` = 0 lasts longer than `SYNC_STAGES`-1 destination clock periods. `SYNC_STAGES` ranges from 2 to 10.
- R6: A rising `dst_clk` edge with `dst_clk_ok` = 0 neither advances nor restarts the release progress. It leaves `dst_rst_n` unchanged.
- R7: From time zero, while `ext_rst_n` is held 0, `dst_rst_n` reads 0 and never shows a 1 before the first release allowed by R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_req | input | 1 | Reset request, synchronous to `src_clk`, active high |
| dst_clk | input | 1 | Destination domain clock |
| dst_clk_ok | input | 1 | Destination clock is stable; release may progress only while it is 1 |
| ext_rst_n | input | 1 | Raw asynchronous external reset, active low |
| dst_rst_n | output | 1 | Destination reset, active low, asserts asynchronously and releases on `dst_clk` |

## Verification
The hardest case to reach is a release that is interrupted partway. In that case the stability qualifier drops, or a fresh request arrives, while the chain holds a partial count. The stimulus reaches this by dropping `dst_clk_ok` one and two destination cycles after the widened request ends. It also sends a second source request while the first is still being widened. The two clocks have periods of 8 ns and 10 ns, with their rising edges on even and odd nanoseconds. Because of this, the bench sees the asynchronous assertion land at many phases of the destination cycle. An external reset is also dropped in the middle of a destination cycle, to show that the output follows it with no clock edge.

// File: rtl/xdom_reset_bridge_pkg.sv
package xdom_reset_bridge_pkg;
  localparam int unsigned MIN_SYNC_STAGES = 2;
  localparam int unsigned MAX_SYNC_STAGES = 10;
  localparam logic        RST_ACTIVE      = 1'b0;
  localparam logic        RST_IDLE        = 1'b1;
endpackage

// File: rtl/req_stretcher.sv
module req_stretcher #(
  parameter int unsigned STRETCH_CYCLES = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic stretched
);
  localparam int unsigned CW = (STRETCH_CYCLES < 2) ? 1 : $clog2(STRETCH_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYCLES - 1);

  logic [CW-1:0] remain_q;

  // The flag comes straight from a flop, so it cannot glitch while the counter decodes.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      remain_q  <= '0;
      stretched <= 1'b0;
    end else if (req) begin
      remain_q  <= RELOAD;
      stretched <= 1'b1;
    end else if (remain_q != '0) begin
      remain_q  <= remain_q - 1'b1;
      stretched <= 1'b1;
    end else begin
      stretched <= 1'b0;
    end
  end

  // R3
  req_stretch_chk: assert property (@(posedge clk) disable iff (!arst_n)
    req |=> stretched);

  // R3
  stretch_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(stretched) |-> !$past(req));
endmodule

// File: rtl/reset_sync_chain.sv
module reset_sync_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic clk_ok,
  input  logic arst_n,
  output logic rst_n
);
  import xdom_reset_bridge_pkg::*;

  localparam int unsigned LCW = $clog2(STAGES + 1);

  logic [STAGES-1:0] chain_q;

  // Every stage clears to the active level, so the chain powers up asserted.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= {STAGES{RST_ACTIVE}};
    end else if (clk_ok) begin
      chain_q <= {chain_q[STAGES-2:0], RST_IDLE};
    end
  end

  assign rst_n = chain_q[STAGES-1];

  // Counts the sampled edges in the current low period, for the width check.
  logic [LCW-1:0] low_edges_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_edges_q <= '0;
    end else if (!rst_n && (low_edges_q < LCW'(STAGES))) begin
      low_edges_q <= low_edges_q + 1'b1;
    end
  end

  // R5
  min_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> (low_edges_q >= LCW'(STAGES)));

  // R4
  release_ok_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> $past(clk_ok));

  // R6
  hold_unstable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !clk_ok |=> $stable(chain_q));
endmodule

// File: rtl/xdom_reset_bridge.sv
module xdom_reset_bridge #(
  parameter int unsigned STRETCH_CYCLES = 4,
  parameter int unsigned SYNC_STAGES    = 3
) (
  input  logic src_clk,
  input  logic src_req,
  input  logic dst_clk,
  input  logic dst_clk_ok,
  input  logic ext_rst_n,
  output logic dst_rst_n
);
  logic req_wide;
  logic chain_clr_n;

  req_stretcher #(
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) u_stretch (
    .clk       (src_clk),
    .arst_n    (ext_rst_n),
    .req       (src_req),
    .stretched (req_wide)
  );

  // Both reset sources clear the chain asynchronously.
  assign chain_clr_n = ext_rst_n & ~req_wide;

  reset_sync_chain #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (dst_clk),
    .clk_ok (dst_clk_ok),
    .arst_n (chain_clr_n),
    .rst_n  (dst_rst_n)
  );

  // R1
  ext_hold_chk: assert property (@(posedge dst_clk)
    !ext_rst_n |-> !dst_rst_n);

  // R2
  req_assert_chk: assert property (@(posedge src_clk) disable iff (!ext_rst_n)
    src_req |=> !dst_rst_n);
endmodule

// File: tb/xdom_reset_bridge_tb.sv
module xdom_reset_bridge_tb;
  localparam int unsigned STRETCH = 4;
  localparam int unsigned STAGES  = 3;
  localparam int DST_HALF = 4;  // 125 MHz
  localparam int SRC_HALF = 5;

  logic src_clk    = 1'b0;
  logic dst_clk    = 1'b0;
  logic src_req    = 1'b0;
  logic dst_clk_ok = 1'b0;
  logic ext_rst_n  = 1'b0;
  logic dst_rst_n;

  int tests  = 0;
  int failed = 0;
  string cur_tag = "R7";

  always #SRC_HALF src_clk = ~src_clk;
  always #DST_HALF dst_clk = ~dst_clk;

  xdom_reset_bridge #(
    .STRETCH_CYCLES(STRETCH),
    .SYNC_STAGES   (STAGES)
  ) u_dut (
    .src_clk   (src_clk),
    .src_req   (src_req),
    .dst_clk   (dst_clk),
    .dst_clk_ok(dst_clk_ok),
    .ext_rst_n (ext_rst_n),
    .dst_rst_n (dst_rst_n)
  );

  // Behavioural reference model.
  int rem_m  = 0;   // source cycles left in the widened request
  int good_m = 0;   // qualified destination edges since the last clear

  always @(posedge src_clk or negedge ext_rst_n) begin
    if (!ext_rst_n)   rem_m <= 0;
    else if (src_req) rem_m <= STRETCH;
    else if (rem_m > 0) rem_m <= rem_m - 1;
  end

  always @(posedge dst_clk) begin
    if (!ext_rst_n || rem_m > 0) good_m <= 0;
    else if (dst_clk_ok && good_m < STAGES) good_m <= good_m + 1;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: dst_rst_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Compared every destination cycle, away from the rising edge.
  always @(negedge dst_clk) begin
    check(cur_tag, dst_rst_n, (ext_rst_n && rem_m == 0 && good_m == STAGES) ? 1'b1 : 1'b0);
  end

  // R4: release only on a rising dst_clk edge; R5: width; R7: no early high.
  time fall_t = 0;
  bit  ext_released = 1'b0;
  always @(negedge dst_rst_n) fall_t = $time;
  always @(posedge dst_rst_n) begin
    tests++;
    if (($time % (2 * DST_HALF)) != DST_HALF) begin
      failed++;
      $display("FAIL R4: release at %0t, expected a dst_clk rising edge", $time);
    end
    tests++;
    if (($time - fall_t) <= (STAGES - 1) * 2 * DST_HALF) begin
      failed++;
      $display("FAIL R5: low width %0t, expected > %0d", $time - fall_t, (STAGES - 1) * 2 * DST_HALF);
    end
    tests++;
    if (!ext_released) begin
      failed++;
      $display("FAIL R7: dst_rst_n=1 at %0t, expected 0 before first release", $time);
    end
  end

  task automatic dwait(input int n);
    repeat (n) @(negedge dst_clk);
    #1;
  endtask

  task automatic req_pulse(input int n);
    @(negedge src_clk);
    src_req = 1'b1;
    repeat (n) @(negedge src_clk);
    src_req = 1'b0;
  endtask

  initial begin
    // R7: reset state at power-up, with no clock edge yet.
    #1;
    check("R7", dst_rst_n, 1'b0);
    dwait(3);
    dst_clk_ok = 1'b1;
    dwait(2);
    cur_tag = "R4";
    ext_released = 1'b1;
    ext_rst_n = 1'b1;
    dwait(10);
    check("R4", dst_rst_n, 1'b1);

    // R2: single-cycle request.
    cur_tag = "R2";
    @(negedge src_clk);
    src_req = 1'b1;
    @(negedge src_clk);
    src_req = 1'b0;
    #1;
    check("R2", dst_rst_n, 1'b0);
    dwait(15);

    // R3: a second request during widening restarts the count.
    cur_tag = "R3";
    req_pulse(1);
    repeat (2) @(negedge src_clk);
    req_pulse(1);
    repeat (STRETCH - 1) @(negedge src_clk);
    #1;
    check("R3", dst_rst_n, 1'b0);
    dwait(15);

    // R6: qualifier drops partway through a release.
    cur_tag = "R6";
    req_pulse(1);
    wait (rem_m == 0);
    dwait(1);
    dst_clk_ok = 1'b0;
    dwait(6);
    check("R6", dst_rst_n, 1'b0);
    dst_clk_ok = 1'b1;
    dwait(1);
    dst_clk_ok = 1'b0;
    dwait(4);
    check("R6", dst_rst_n, 1'b0);
    dst_clk_ok = 1'b1;
    dwait(10);

    // R1: external reset dropped in the middle of a destination cycle.
    cur_tag = "R1";
    @(negedge dst_clk);
    #3;
    ext_rst_n = 1'b0;
    #1;
    check("R1", dst_rst_n, 1'b0);
    dwait(2);
    ext_rst_n = 1'b1;
    dwait(10);

    // R5: multi-cycle request, then a clean release.
    cur_tag = "R5";
    req_pulse(3);
    dwait(15);
    check("R5", dst_rst_n, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #200000;
    tests++;
    failed++;
    $display("FAIL watchdog: run not finished at %0t, expected completion", $time);
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule